// File: doc/BRIEF.md
# Narrow-to-Wide Packing FIFO with Exact Fill Count

This block is a single-clock FIFO. It accepts narrow words on its write side and returns wide words on its read side. Eight consecutive 16-bit writes are packed into one 128-bit read word. The storage holds 256 wide words, which is 2048 narrow words.

The block counts its fill level exactly on every cycle, in narrow units, and also reports it in wide units. Upstream logic sets a stop level, in wide words, through a runtime input. The write side is refused from the first cycle in which the stored amount has reached that level. The producer can therefore fill the buffer to a precise point, with no extra write and no early stop.

The read side works on request. A request is honoured only when at least one complete wide word is stored. The data arrives one cycle after an honoured request, marked by a valid strobe.

Top module: `wc_pack_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it is released, both fill counts are 0 and rd_valid is 0.
- R2: A write is taken on a rising clock edge when wr_valid and wr_ready are both 1. A write offered while wr_ready is 0 is not stored and is not counted.
- R3: Within each 128-bit read word, the first 16-bit write of the group occupies bits [15:0], and each later write occupies the next higher 16-bit lane. Wide words are read out in the order they were filled.
- R4: wr_ready is 0 exactly when wr_count is at least thresh × 8. With wr_valid held high from empty, exactly thresh × 8 writes are taken.
- R5: A read request is taken only when rd_count is at least 1. A request made with rd_count equal to 0 leaves the counts unchanged, produces no rd_valid, and leaves the read position unchanged.
- R6: After each edge, wr_count equals its previous value plus 1 for a taken write, minus 8 for a taken read, or minus 7 when both are taken. rd_count always equals wr_count divided by 8, rounded down.
- R7: rd_valid is 1 in exactly the cycle after a taken read request, and rd_data holds the requested word in that cycle.
- R8: wr_ready is 0 at a fill of 2048 narrow words, whatever the value of thresh. Storage positions wrap, so data stays in order across the end of the storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Producer offers a narrow word |
| wr_data | input | 16 | Narrow word to store |
| wr_ready | output | 1 | The block will take the offered word |
| rd_req | input | 1 | Consumer asks for one wide word |
| rd_data | output | 128 | Wide word read out |
| rd_valid | output | 1 | rd_data holds a requested word |
| thresh | input | 9 | Stop level in wide words (0 to 256) |
| wr_count | output | 12 | Exact fill level in narrow words |
| rd_count | output | 9 | Fill level in complete wide words |

## Verification
The bound checker watches several properties on every cycle. It checks that the fill level never exceeds capacity. It checks that each count update matches the write and read traffic of the previous cycle. It checks that no taken write carries the fill past the stop level, and that rd_valid follows exactly the taken requests. Lane placement, ordering across wraparound, the exact number of writes taken before a stop, and the read position after an ignored request can only be shown by the bench. The bench does this by tracking a model queue through directed scenarios and comparing every wide word it reads back.

// File: rtl/wc_pack_pkg.sv
// Package wc_pack_pkg
// Shared defaults and the per-cycle operation type for the packing FIFO.
// Assumes every user derives its widths from these defaults or from
// parameters that override them.
package wc_pack_pkg;
    localparam int NARROW_W_DEF = 16;
    localparam int RATIO_DEF    = 8;
    localparam int WIDE_DEPTH_DEF = 256;

    // What the occupancy counter must do in a given cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } occ_op_e;
endpackage

// File: rtl/wc_lane_ram.sv
// Module wc_lane_ram
// Simple dual-port synchronous RAM of wide words with a narrow-lane write port.
// Each write stores one lane. A read returns a whole word one cycle later.
// Assumes the controller never reads the word that is being written in the
// same cycle.
module wc_lane_ram #(
    parameter int LANE_W = 16,
    parameter int LANES  = 8,
    parameter int WORDS  = 256,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int SEL_W  = $clog2(LANES),
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [SEL_W-1:0]  wlane,
    input  logic [LANE_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [WORDS];

    // Lane write into the addressed word
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr][wlane*LANE_W +: LANE_W] <= wdata;
        end
    end

    // Registered whole-word read
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/wc_occ_ctrl.sv
// Module wc_occ_ctrl
// Holds the write position (in narrow units), the read position (in wide
// words) and the exact occupancy (in narrow units). It decides acceptance on
// both sides. Assumes thresh is given in wide words and is at most WORDS.
module wc_occ_ctrl
    import wc_pack_pkg::*;
#(
    parameter int RATIO = 8,
    parameter int WORDS = 256,
    localparam int SEL_W  = $clog2(RATIO),
    localparam int ADDR_W = $clog2(WORDS),
    localparam int WPTR_W = ADDR_W + SEL_W,
    localparam int OCC_W  = WPTR_W + 1,
    localparam int THR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              rd_req,
    input  logic [THR_W-1:0]  thresh,
    output logic              wr_ready,
    output logic              wr_take,
    output logic              rd_take,
    output logic [ADDR_W-1:0] waddr,
    output logic [SEL_W-1:0]  wlane,
    output logic [ADDR_W-1:0] raddr,
    output logic [OCC_W-1:0]  occ
);
    localparam logic [OCC_W-1:0] CAP     = OCC_W'(WORDS * RATIO);
    localparam logic [OCC_W-1:0] STEP_RD = OCC_W'(RATIO);

    logic [WPTR_W-1:0] wptr;
    logic [ADDR_W-1:0] rptr;
    logic [OCC_W-1:0]  limit;
    occ_op_e           op;

    // Stop level expressed in narrow units
    always_comb limit = OCC_W'(thresh) << SEL_W;

    // Acceptance on both sides from the current occupancy only
    always_comb begin
        wr_ready = (occ < limit) && (occ < CAP);
        wr_take  = wr_valid && wr_ready;
        rd_take  = rd_req && (occ >= STEP_RD);
        op       = occ_op_e'({rd_take, wr_take});
    end

    // Split the write position into word address and lane
    always_comb begin
        waddr = wptr[WPTR_W-1:SEL_W];
        wlane = wptr[SEL_W-1:0];
        raddr = rptr;
    end

    // Advance the positions, which wrap modulo the storage size
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_take) wptr <= wptr + 1'b1;
            if (rd_take) rptr <= rptr + 1'b1;
        end
    end

    // Exact occupancy: +1 per narrow write, -RATIO per wide read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            unique case (op)
                OP_PUSH: occ <= occ + 1'b1;
                OP_POP:  occ <= occ - STEP_RD;
                OP_BOTH: occ <= occ + 1'b1 - STEP_RD;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/wc_pack_fifo.sv
// Module wc_pack_fifo
// Top of the narrow-to-wide packing FIFO. It ties the occupancy controller
// to the lane RAM and registers the read strobe. Assumes a single clock and a
// synchronous active-low reset. The RAM contents are not cleared by reset.
module wc_pack_fifo
    import wc_pack_pkg::*;
#(
    parameter int NARROW_W = NARROW_W_DEF,
    parameter int RATIO    = RATIO_DEF,
    parameter int WORDS    = WIDE_DEPTH_DEF,
    localparam int WIDE_W  = NARROW_W * RATIO,
    localparam int SEL_W   = $clog2(RATIO),
    localparam int ADDR_W  = $clog2(WORDS),
    localparam int OCC_W   = ADDR_W + SEL_W + 1,
    localparam int THR_W   = ADDR_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [NARROW_W-1:0] wr_data,
    output logic                wr_ready,
    input  logic                rd_req,
    output logic [WIDE_W-1:0]   rd_data,
    output logic                rd_valid,
    input  logic [THR_W-1:0]    thresh,
    output logic [OCC_W-1:0]    wr_count,
    output logic [THR_W-1:0]    rd_count
);
    logic              wr_take;
    logic              rd_take;
    logic [ADDR_W-1:0] waddr;
    logic [SEL_W-1:0]  wlane;
    logic [ADDR_W-1:0] raddr;
    logic [OCC_W-1:0]  occ;

    wc_occ_ctrl #(
        .RATIO (RATIO),
        .WORDS (WORDS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .rd_req   (rd_req),
        .thresh   (thresh),
        .wr_ready (wr_ready),
        .wr_take  (wr_take),
        .rd_take  (rd_take),
        .waddr    (waddr),
        .wlane    (wlane),
        .raddr    (raddr),
        .occ      (occ)
    );

    wc_lane_ram #(
        .LANE_W (NARROW_W),
        .LANES  (RATIO),
        .WORDS  (WORDS)
    ) u_ram (
        .clk   (clk),
        .we    (wr_take),
        .waddr (waddr),
        .wlane (wlane),
        .wdata (wr_data),
        .re    (rd_take),
        .raddr (raddr),
        .rdata (rd_data)
    );

    // Read strobe follows a taken request by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_take;
    end

    // Report occupancy in both units
    always_comb begin
        wr_count = occ;
        rd_count = THR_W'(occ >> SEL_W);
    end
endmodule

// File: rtl/wc_pack_fifo_chk.sv
// Module wc_pack_fifo_chk
// Checker bound to wc_pack_fifo. It watches only the top-level ports and
// relates them across cycles.
module wc_pack_fifo_chk #(
    parameter int RATIO = 8,
    parameter int WORDS = 256,
    localparam int SEL_W = $clog2(RATIO),
    localparam int OCC_W = $clog2(WORDS) + SEL_W + 1,
    localparam int THR_W = $clog2(WORDS) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             rd_req,
    input logic             rd_valid,
    input logic [THR_W-1:0] thresh,
    input logic [OCC_W-1:0] wr_count,
    input logic [THR_W-1:0] rd_count
);
    localparam logic [OCC_W-1:0] CAP = OCC_W'(WORDS * RATIO);

    logic push, pop;
    logic [OCC_W-1:0] lim;
    always_comb begin
        push = wr_valid && wr_ready;
        pop  = rd_req && (rd_count != '0);
        lim  = OCC_W'(thresh) << SEL_W;
    end

    // R8
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count <= CAP);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> wr_count == OCC_W'($past(wr_count) + OCC_W'($past(push))
                                    - (OCC_W'($past(pop)) << SEL_W)));

    // R4
    stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> wr_count <= $past(lim));

    // R7
    rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> rd_valid);

    // R5
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> !rd_valid);
endmodule

bind wc_pack_fifo wc_pack_fifo_chk #(.RATIO(RATIO), .WORDS(WORDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .thresh   (thresh),
    .wr_count (wr_count),
    .rd_count (rd_count)
);

// File: tb/test_wc_pack_fifo.sv
// Bench test_wc_pack_fifo
// Directed scenarios against a model queue of narrow words. Every step
// compares the ready, count and read outputs with the model.
module test_wc_pack_fifo;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_valid;
    logic [15:0]  wr_data;
    logic         wr_ready;
    logic         rd_req;
    logic [127:0] rd_data;
    logic         rd_valid;
    logic [8:0]   thresh;
    logic [11:0]  wr_count;
    logic [8:0]   rd_count;

    int errors = 0;
    int checks = 0;

    // Model state
    logic [15:0]  mq [4096];
    int           mhead = 0;
    int           mtail = 0;
    int           mocc  = 0;
    int           wseq  = 0;
    logic         exp_rv = 1'b0;
    logic [127:0] exp_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wc_pack_fifo i_wc_pack_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_req(rd_req), .rd_data(rd_data),
        .rd_valid(rd_valid), .thresh(thresh), .wr_count(wr_count),
        .rd_count(rd_count)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive, predict, advance, compare
    task automatic step(input bit wv, input bit rq);
        bit acc_w, acc_r;
        @(negedge clk);
        wr_valid = wv;
        wr_data  = 16'(wseq * 13 + 7);
        rd_req   = rq;
        #1;
        acc_w = wv && (mocc < int'(thresh) * 8) && (mocc < 2048);
        acc_r = rq && (mocc >= 8);
        chk(wr_ready == ((mocc < int'(thresh) * 8) && (mocc < 2048)), "R4 ready",
            128'(wr_ready), 128'((mocc < int'(thresh) * 8) && (mocc < 2048)));
        if (acc_r) begin
            for (int k = 0; k < 8; k++) exp_rd[k*16 +: 16] = mq[(mhead + k) % 4096];
            mhead = (mhead + 8) % 4096;
        end
        if (acc_w) begin
            mq[mtail] = wr_data;
            mtail = (mtail + 1) % 4096;
            wseq++;
        end
        mocc = mocc + (acc_w ? 1 : 0) - (acc_r ? 8 : 0);
        exp_rv = acc_r;
        @(posedge clk);
        #1;
        chk(rd_valid == exp_rv, "R7 rd_valid", 128'(rd_valid), 128'(exp_rv));
        if (exp_rv) chk(rd_data == exp_rd, "R3 rd_data", rd_data, exp_rd);
        chk(wr_count == 12'(mocc), "R6 wr_count", 128'(wr_count), 128'(mocc));
        chk(rd_count == 9'(mocc / 8), "R6 rd_count", 128'(rd_count), 128'(mocc / 8));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_valid = 1'b0; rd_req = 1'b0; wr_data = '0; thresh = 9'd200;
        repeat (3) @(posedge clk);
        #1;
        chk(wr_count == 0 && rd_count == 0 && rd_valid == 0, "R1 during reset",
            128'(wr_count), 128'(0));
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(wr_count == 0 && rd_count == 0 && rd_valid == 0, "R1 after reset",
            128'(wr_count), 128'(0));
    endtask

    task automatic t_pack();
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0);
        chk(rd_count == 2, "R2 two words packed", 128'(rd_count), 128'(2));
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        chk(wr_count == 0, "R3 drained", 128'(wr_count), 128'(0));
    endtask

    task automatic t_empty_read();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk(rd_valid == 0 && wr_count == 5, "R5 partial word ignored",
            128'(wr_count), 128'(5));
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk(rd_valid == 1, "R5 read position unchanged", 128'(rd_valid), 128'(1));
    endtask

    task automatic t_threshold();
        int taken;
        thresh = 9'd3;
        taken = 0;
        for (int i = 0; i < 40; i++) begin
            if (wr_ready) taken++;
            step(1'b1, 1'b0);
        end
        chk(taken == 24 && wr_count == 24, "R4 exact stop", 128'(taken), 128'(24));
        step(1'b1, 1'b1);
        chk(wr_count == 16, "R4 read frees room", 128'(wr_count), 128'(16));
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
        chk(wr_count == 24 && !wr_ready, "R4 stops again", 128'(wr_count), 128'(24));
        thresh = 9'd0;
        step(1'b1, 1'b0);
        chk(wr_count == 24, "R2 refused write not stored", 128'(wr_count), 128'(24));
    endtask

    task automatic t_both();
        thresh = 9'd200;
        step(1'b1, 1'b1);
        chk(wr_count == 17, "R6 write and read together", 128'(wr_count), 128'(17));
        while (mocc >= 8) step(1'b0, 1'b1);
        step(1'b0, 1'b1);
    endtask

    task automatic t_full_wrap();
        thresh = 9'd256;
        for (int i = 0; i < 2060; i++) step(1'b1, 1'b0);
        chk(wr_count == 2048 && rd_count == 256 && !wr_ready, "R8 full",
            128'(wr_count), 128'(2048));
        for (int i = 0; i < 256; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 300; i++) step(1'b0, 1'b1);
        chk(wr_count == 12'(mocc), "R8 after wrap", 128'(wr_count), 128'(mocc));
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_pack();
        t_empty_read();
        t_threshold();
        t_both();
        t_full_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule